// File: doc/BRIEF.md
# Serial-Addressed Wiper Code Bank

This block holds the tap settings of a multi-channel digitally controlled variable resistor. A three-wire serial port (active-low select, serial clock, data) delivers 11-bit frames. Each frame carries a channel number and an 8-bit wiper code. When the frame ends, the named channel's latch takes the code and all other latches keep their values. Channels can be written in any order, one frame at a time.

All latches start at midscale after the power-on reset. They go back to midscale whenever the preset input is asserted. A shutdown input makes every channel report terminal A open and the wiper on terminal B (code 0). The stored codes are kept, so releasing shutdown brings back the earlier settings. The three serial lines are asynchronous to the system clock. Each passes through a synchroniser before its edges are detected.

Top module: `wiper_bank_top`

## Requirements
- R1: A frame is 11 bits shifted on serial clock rising edges while select is low. The first three bits form the channel address, most significant bit first. The next eight bits form the code, most significant bit first.
- R2: A latch is written only when select rises after exactly 11 serial clock rising edges. A frame of 10 or 12 bits changes no latch.
- R3: A valid frame updates only the addressed channel. Every other channel keeps its code.
- R4: A frame whose address is NUM_CH or larger changes no latch.
- R5: After the power-on reset (rst_ni low) every channel holds code 0x80.
- R6: preset_i is sampled on clk_i. While it is high, every latch is loaded with 0x80. Preset wins over a frame that completes in the same cycle, so that frame is lost.
- R7: While shutdown_i is high, every tap_code_o field is 0 and every a_open_o bit is 1. Latches keep their values and still accept frames. After release, each output shows its stored code again.
- R8: While shutdown_i is low, a_open_o is all zero and each tap_code_o field (channel k at bits 8k+7..8k) equals that channel's stored code.
- R9: Serial clock edges while select is high shift nothing. Each frame starts counting from zero.
- R10: Codes 0x00 and 0xFF are stored and shown unchanged.
- R11: A valid frame's code appears on tap_code_o no later than the fourth clk_i rising edge after select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| preset_i | input | 1 | Synchronous midscale preset, active high |
| shutdown_i | input | 1 | Shutdown request, active high |
| cs_ni | input | 1 | Serial select, active low (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data in (asynchronous) |
| tap_code_o | output | NUM_CH*8 | Effective tap code per channel, channel k at bits 8k+7..8k |
| a_open_o | output | NUM_CH | Terminal-A-open flag per channel |

## Verification
The outputs follow the latches combinationally. A corrupted latch, a wrong decode or a misordered shift register therefore shows up as a wrong tap field within four clocks of the frame's end. A frame-length counter that miscounts shows up as a write that should not happen, or one that is missing, after the same delay. A shutdown override that leaks into storage only becomes visible when shutdown is released, so the bench always compares every channel after release.

// File: rtl/wb_pkg.sv
package wb_pkg;
    localparam int CODE_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int FRAME_BITS = ADDR_W + CODE_W;
    localparam logic [CODE_W-1:0] MIDSCALE = 8'h80;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/wb_sync.sv
module wb_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wb_frame_rx.sv
module wb_frame_rx
    import wb_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    cs_n_s,
    input  logic    sclk_s,
    input  logic    sdi_s,
    output wr_req_t wr_o
);
    localparam int CNT_W   = $clog2(FRAME_BITS + 2);
    localparam int CNT_SAT = FRAME_BITS + 1;

    typedef struct packed {
        logic                  cs_prev;
        logic                  sclk_prev;
        logic [FRAME_BITS-1:0] shreg;
        logic [CNT_W-1:0]      cnt;
        wr_req_t               wr;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   sclk_rise, cs_rise;

    always_comb begin
        st_d           = st_q;
        st_d.cs_prev   = cs_n_s;
        st_d.sclk_prev = sclk_s;
        st_d.wr.valid  = 1'b0;
        sclk_rise      = sclk_s && !st_q.sclk_prev;
        cs_rise        = cs_n_s && !st_q.cs_prev;

        if (cs_rise) begin
            st_d.wr.valid = (st_q.cnt == CNT_W'(FRAME_BITS));
            st_d.wr.addr  = st_q.shreg[FRAME_BITS-1 -: ADDR_W];
            st_d.wr.data  = st_q.shreg[CODE_W-1:0];
            st_d.cnt      = '0;
        end else if (cs_n_s) begin
            st_d.cnt = '0;
        end else if (sclk_rise) begin
            st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], sdi_s};
            if (st_q.cnt != CNT_W'(CNT_SAT)) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q           <= '0;
            st_q.cs_prev   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_o = st_q.wr;
endmodule

// File: rtl/wb_latch_bank.sv
module wb_latch_bank
    import wb_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           preset_i,
    input  wr_req_t                        wr_i,
    output logic [NUM_CH-1:0][CODE_W-1:0]  lat_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] lat;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preset_i) begin
            st_d.lat = {NUM_CH{MIDSCALE}};
        end else if (wr_i.valid) begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (32'(wr_i.addr) == k) st_d.lat[k] = wr_i.data;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.lat <= {NUM_CH{MIDSCALE}};
        else         st_q     <= st_d;
    end

    assign lat_o = st_q.lat;
endmodule

// File: rtl/wb_out_stage.sv
module wb_out_stage
    import wb_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic                          shutdown_i,
    input  logic [NUM_CH-1:0][CODE_W-1:0] lat_i,
    output logic [NUM_CH*CODE_W-1:0]      tap_o,
    output logic [NUM_CH-1:0]             a_open_o
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        always_comb begin
            tap_o[k*CODE_W +: CODE_W] = shutdown_i ? '0 : lat_i[k];
            a_open_o[k]               = shutdown_i;
        end
    end
endmodule

// File: rtl/wiper_bank_top.sv
module wiper_bank_top
    import wb_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     preset_i,
    input  logic                     shutdown_i,
    input  logic                     cs_ni,
    input  logic                     sclk_i,
    input  logic                     sdi_i,
    output logic [NUM_CH*CODE_W-1:0] tap_code_o,
    output logic [NUM_CH-1:0]        a_open_o
);
    logic [2:0]                    ser_s;
    wr_req_t                       wr_req;
    logic [NUM_CH-1:0][CODE_W-1:0] lat;
    logic [NUM_CH*CODE_W-1:0]      lat_flat;

    wb_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({cs_ni, sclk_i, sdi_i}),
        .sync_o  (ser_s)
    );

    wb_frame_rx u_rx (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cs_n_s (ser_s[2]),
        .sclk_s (ser_s[1]),
        .sdi_s  (ser_s[0]),
        .wr_o   (wr_req)
    );

    wb_latch_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .preset_i (preset_i),
        .wr_i     (wr_req),
        .lat_o    (lat)
    );

    assign lat_flat = lat;

    wb_out_stage #(.NUM_CH(NUM_CH)) u_out (
        .shutdown_i (shutdown_i),
        .lat_i      (lat),
        .tap_o      (tap_code_o),
        .a_open_o   (a_open_o)
    );
endmodule

// File: rtl/wb_bank_chk.sv
module wb_bank_chk #(
    parameter int NUM_CH = 6
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  preset_i,
    input logic                  shutdown_i,
    input logic [NUM_CH*8-1:0]   tap_code_o,
    input logic [NUM_CH-1:0]     a_open_o,
    input logic                  wr_valid,
    input logic [2:0]            wr_addr,
    input logic [7:0]            wr_data,
    input logic [NUM_CH*8-1:0]   lat_flat
);
    assert_preset_mid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        preset_i |=> (lat_flat == {NUM_CH{8'h80}}));

    assert_shutdown_override_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shutdown_i |-> (tap_code_o == '0 && a_open_o == '1));

    assert_normal_passthru_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shutdown_i |-> (tap_code_o == lat_flat && a_open_o == '0));

    assert_bad_addr_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid && 32'(wr_addr) >= NUM_CH && !preset_i) |=> $stable(lat_flat));

    assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_valid && !preset_i) |=> $stable(lat_flat));

    assert_write_lands_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid && 32'(wr_addr) < NUM_CH && !preset_i)
        |=> (lat_flat[$past(wr_addr)*8 +: 8] == $past(wr_data)));

    assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid |=> !wr_valid);
endmodule

bind wiper_bank_top wb_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .preset_i   (preset_i),
    .shutdown_i (shutdown_i),
    .tap_code_o (tap_code_o),
    .a_open_o   (a_open_o),
    .wr_valid   (wr_req.valid),
    .wr_addr    (wr_req.addr),
    .wr_data    (wr_req.data),
    .lat_flat   (lat_flat)
);

// File: tb/wiper_bank_top_bench.sv
module wiper_bank_top_bench;
    localparam int NUM_CH = 6;
    localparam int NVEC   = 10;
    localparam logic [10:0] VEC [NVEC] = '{
        {3'd0, 8'h12}, {3'd5, 8'hFF}, {3'd3, 8'h00}, {3'd7, 8'h55},
        {3'd1, 8'hA5}, {3'd6, 8'h01}, {3'd2, 8'h7E}, {3'd4, 8'h81},
        {3'd0, 8'hC3}, {3'd5, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0, preset = 1'b0, shdn = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [NUM_CH*8-1:0] tap;
    logic [NUM_CH-1:0]   aopen;
    logic [7:0] expv [NUM_CH];
    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wiper_bank_top #(.NUM_CH(NUM_CH)) u_wiper_bank_top (
        .clk_i(clk), .rst_ni(rst_n), .preset_i(preset), .shutdown_i(shdn),
        .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .tap_code_o(tap), .a_open_o(aopen)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int k = 0; k < NUM_CH; k++) chk(req, int'(tap[k*8 +: 8]), int'(expv[k]));
        chk(req, int'(aopen), 0);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] word, input int nbits);
        cs_n = 1'b0;
        wait_clk(3);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = word[i];
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
        end
        wait_clk(3);
        cs_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NUM_CH; k++) expv[k] = 8'h80;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        chk_all("R5");

        // vector table: R1 R3 R4 R10
        for (int v = 0; v < NVEC; v++) begin
            send({5'b0, VEC[v]}, 11);
            wait_clk(8);
            if (int'(VEC[v][10:8]) < NUM_CH) expv[VEC[v][10:8]] = VEC[v][7:0];
            chk_all(int'(VEC[v][10:8]) < NUM_CH ? "R3" : "R4");
        end

        // R11 latency: four edges after select rises
        send({5'b0, 3'd3, 8'h5A}, 11);
        @(posedge clk); @(posedge clk); @(posedge clk); @(posedge clk);
        #1;
        expv[3] = 8'h5A;
        chk("R11", int'(tap[3*8 +: 8]), 'h5A);

        // R2 short and long frames
        send({5'b0, 3'd1, 8'h33}, 10);
        wait_clk(8);
        chk_all("R2");
        send({4'b0, 3'd1, 8'h33, 1'b1}, 12);
        wait_clk(8);
        chk_all("R2");

        // R9 clocks while select high are ignored
        for (int i = 0; i < 5; i++) begin
            sdi = i[0];
            wait_clk(3); sclk = 1'b1; wait_clk(3); sclk = 1'b0;
        end
        wait_clk(4);
        chk_all("R9");
        send({5'b0, 3'd2, 8'hE7}, 11);
        wait_clk(8);
        expv[2] = 8'hE7;
        chk_all("R9");

        // R7 shutdown override, storage kept and writable
        shdn = 1'b1;
        wait_clk(1);
        chk("R7", int'(aopen), (1 << NUM_CH) - 1);
        chk("R7", int'(tap == '0), 1);
        send({5'b0, 3'd4, 8'h3C}, 11);
        wait_clk(8);
        expv[4] = 8'h3C;
        chk("R7", int'(tap == '0), 1);
        shdn = 1'b0;
        wait_clk(1);
        chk_all("R7");
        chk_all("R8");

        // R6 preset, and priority over a frame ending under it
        preset = 1'b1;
        send({5'b0, 3'd1, 8'h11}, 11);
        wait_clk(8);
        preset = 1'b0;
        wait_clk(1);
        for (int k = 0; k < NUM_CH; k++) expv[k] = 8'h80;
        chk_all("R6");

        // R10 extremes after preset
        send({5'b0, 3'd0, 8'hFF}, 11);
        wait_clk(8);
        send({5'b0, 3'd5, 8'h00}, 11);
        wait_clk(8);
        expv[0] = 8'hFF; expv[5] = 8'h00;
        chk_all("R10");

        // R5 reset again returns midscale
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(2);
        for (int k = 0; k < NUM_CH; k++) expv[k] = 8'h80;
        chk_all("R5");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule